// File: doc/BRIEF.md
# Interrupt Cycle and I/O Flag Controller

This block holds the character-device flags and the interrupt machinery of a small accumulator machine. It keeps an 8-bit input character register with a ready flag, an 8-bit output character register with a free flag, and an interrupt-enable flag. A keyboard-side strobe deposits a character and raises the ready flag. A printer-side accept pulse marks the output register free again. Instruction execution elsewhere reads and writes these registers and pulses the enable flag on and off.

When the host sequencer reports that an instruction has finished executing, the block samples the request condition: enable set and at least one device flag set. If the condition holds, it raises an interrupt-busy flag, which tells the host to hold off its normal fetch. The block then runs a fixed three-step cycle by itself. Step one latches the current program counter as the return address and the save location as the address. Step two writes the return address to the save location and loads the program counter with that location. Step three increments the program counter so execution resumes one word higher. It also drops the enable flag and signals cycle completion.

Top module: `irq_flag_ctl`

## Requirements
- R1: After synchronous reset: in_ready=0, out_free=1, ien=0, irq_busy=0, mem_we=0, pc_load=0, pc_inc=0, cycle_done=0, in_data=0, out_data=0.
- R2: A kbd_strobe makes in_data equal kbd_char and in_ready 1 one cycle later. An in_read alone clears in_ready one cycle later. When both arrive together, the strobe wins (in_ready stays 1).
- R3: An out_write makes out_data equal out_char and out_free 0 one cycle later. A prn_accept alone sets out_free one cycle later. When both arrive together, the write wins (out_free 0).
- R4: An ien_set pulse sets ien one cycle later, and an ien_clr pulse clears it. When both arrive together, ien_clr wins.
- R5: irq_busy rises one cycle after a cycle in which exec_done=1, ien=1 and (in_ready or out_free)=1. It stays 0 when exec_done arrives with ien=0 or with both device flags 0, and when the condition holds without exec_done.
- R6: Two cycles after irq_busy rises, mem_we and pc_load are high for exactly one cycle. In that cycle mem_addr=0 and pc_load_val=0, and mem_wdata equals the pc_in value present in the first busy cycle, zero-extended to 16 bits.
- R7: In the cycle after the write, pc_inc and cycle_done pulse for one cycle, while ien and irq_busy read 0. An ien_set applied during the final step does not survive.
- R8: While irq_busy is 1, exec_done has no effect: the cycle still ends after its three steps. The cycle leaves in_ready, out_free, in_data and out_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kbd_strobe | input | 1 | New input character present |
| kbd_char | input | 8 | Input character |
| in_read | input | 1 | Execution reads the input register |
| in_data | output | 8 | Input character register |
| in_ready | output | 1 | Input-ready flag |
| out_write | input | 1 | Execution writes the output register |
| out_char | input | 8 | Character to output |
| prn_accept | input | 1 | Device has taken the output character |
| out_data | output | 8 | Output character register |
| out_free | output | 1 | Output-free flag |
| ien_set | input | 1 | Enable interrupts pulse |
| ien_clr | input | 1 | Disable interrupts pulse |
| ien | output | 1 | Interrupt-enable flag |
| exec_done | input | 1 | Instruction execution finished this cycle |
| pc_in | input | 12 | Current program counter |
| irq_busy | output | 1 | Interrupt cycle in progress; fetch suppressed |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| pc_load | output | 1 | Load program counter with pc_load_val |
| pc_load_val | output | 12 | Value for program counter load |
| pc_inc | output | 1 | Increment program counter |
| cycle_done | output | 1 | Interrupt cycle complete |

## Verification
The bench changes pc_in right after the first busy cycle. A design that captured the return address late would then store the wrong value. Simultaneous strobe/read and write/accept pairs expose a wrong flag priority, which would lose a character or mark the printer free early. The bench pulses ien_set during the final step and exec_done throughout the cycle. A design that let either through would re-enter the interrupt cycle forever. Requests are also tried with enable off, with no flags set, and without exec_done, so that a block sampling at the wrong time is caught.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef enum logic [1:0] {
    STEP_SAVE  = 2'd0,
    STEP_WRITE = 2'd1,
    STEP_JUMP  = 2'd2
  } irq_step_e;
endpackage

// File: rtl/irq_io_flags.sv
module irq_io_flags #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kbd_strobe,
  input  logic [CHAR_W-1:0] kbd_char,
  input  logic              in_read,
  input  logic              out_write,
  input  logic [CHAR_W-1:0] out_char,
  input  logic              prn_accept,
  output logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_free
);
  // Input side: a fresh character outranks a read of the old one.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_data  <= '0;
      in_ready <= 1'b0;
    end else if (kbd_strobe) begin
      in_data  <= kbd_char;
      in_ready <= 1'b1;
    end else if (in_read) begin
      in_ready <= 1'b0;
    end
  end

  // Output side: a new write outranks the device accept.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
      out_free <= 1'b1;
    end else if (out_write) begin
      out_data <= out_char;
      out_free <= 1'b0;
    end else if (prn_accept) begin
      out_free <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_cycle_seq.sv
module irq_cycle_seq
  import irq_flag_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int SAVE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_done,
  input  logic              ien_set,
  input  logic              ien_clr,
  input  logic              dev_flag,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              ien,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_load_val,
  output logic              pc_inc,
  output logic              cycle_done
);
  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);

  irq_step_e         step;
  logic [ADDR_W-1:0] ar_q;
  logic [DATA_W-1:0] tr_q;
  logic              last_step;

  assign last_step   = busy && (step == STEP_JUMP);
  assign pc_load_val = SAVE_A;

  // Enable flag: sequence clear, then disable, then enable.
  always_ff @(posedge clk) begin
    if (rst)            ien <= 1'b0;
    else if (last_step) ien <= 1'b0;
    else if (ien_clr)   ien <= 1'b0;
    else if (ien_set)   ien <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      step       <= STEP_SAVE;
      ar_q       <= '0;
      tr_q       <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      pc_load    <= 1'b0;
      pc_inc     <= 1'b0;
      cycle_done <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      pc_load    <= 1'b0;
      pc_inc     <= 1'b0;
      cycle_done <= 1'b0;
      if (!busy) begin
        step <= STEP_SAVE;
        if (exec_done && ien && dev_flag) busy <= 1'b1;
      end else begin
        unique case (step)
          STEP_SAVE: begin
            ar_q <= SAVE_A;
            tr_q <= DATA_W'(pc_in);
            step <= STEP_WRITE;
          end
          STEP_WRITE: begin
            mem_we    <= 1'b1;
            mem_addr  <= ar_q;
            mem_wdata <= tr_q;
            pc_load   <= 1'b1;
            step      <= STEP_JUMP;
          end
          STEP_JUMP: begin
            pc_inc     <= 1'b1;
            cycle_done <= 1'b1;
            busy       <= 1'b0;
            step       <= STEP_SAVE;
          end
          default: step <= STEP_SAVE;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl #(
  parameter int CHAR_W    = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int SAVE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kbd_strobe,
  input  logic [CHAR_W-1:0] kbd_char,
  input  logic              in_read,
  output logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_write,
  input  logic [CHAR_W-1:0] out_char,
  input  logic              prn_accept,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_free,
  input  logic              ien_set,
  input  logic              ien_clr,
  output logic              ien,
  input  logic              exec_done,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              irq_busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_load_val,
  output logic              pc_inc,
  output logic              cycle_done
);
  logic dev_flag;
  assign dev_flag = in_ready | out_free;

  irq_io_flags #(.CHAR_W(CHAR_W)) u_flags (
    .clk(clk), .rst(rst),
    .kbd_strobe(kbd_strobe), .kbd_char(kbd_char), .in_read(in_read),
    .out_write(out_write), .out_char(out_char), .prn_accept(prn_accept),
    .in_data(in_data), .in_ready(in_ready),
    .out_data(out_data), .out_free(out_free)
  );

  irq_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAVE_ADDR(SAVE_ADDR)) u_seq (
    .clk(clk), .rst(rst),
    .exec_done(exec_done), .ien_set(ien_set), .ien_clr(ien_clr),
    .dev_flag(dev_flag), .pc_in(pc_in),
    .ien(ien), .busy(irq_busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_load(pc_load), .pc_load_val(pc_load_val),
    .pc_inc(pc_inc), .cycle_done(cycle_done)
  );
endmodule

// File: rtl/irq_flag_ctl_chk.sv
module irq_flag_ctl_chk #(
  parameter int ADDR_W    = 12,
  parameter int SAVE_ADDR = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              kbd_strobe,
  input logic              out_write,
  input logic              ien_set,
  input logic              ien_clr,
  input logic              exec_done,
  input logic              in_ready,
  input logic              out_free,
  input logic              ien,
  input logic              irq_busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pc_load,
  input logic              pc_inc,
  input logic              cycle_done
);
  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);

  p_strobe_sets_r2: assert property (@(posedge clk) disable iff (rst)
    kbd_strobe |=> in_ready);

  p_write_clears_r3: assert property (@(posedge clk) disable iff (rst)
    out_write |=> !out_free);

  p_clr_wins_r4: assert property (@(posedge clk) disable iff (rst)
    ien_clr |=> !ien);

  p_busy_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_busy) |-> ($past(exec_done) && $past(ien)));

  p_save_addr_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == SAVE_A && pc_load && irq_busy));

  p_write_once_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (!mem_we && pc_inc && cycle_done));

  p_done_state_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_done |-> (!ien && !irq_busy));

  p_ien_set_r4: assert property (@(posedge clk) disable iff (rst)
    (ien_set && !ien_clr && !irq_busy) |=> ien);
endmodule

bind irq_flag_ctl irq_flag_ctl_chk #(.ADDR_W(ADDR_W), .SAVE_ADDR(SAVE_ADDR)) u_chk (
  .clk(clk), .rst(rst), .kbd_strobe(kbd_strobe), .out_write(out_write),
  .ien_set(ien_set), .ien_clr(ien_clr), .exec_done(exec_done),
  .in_ready(in_ready), .out_free(out_free), .ien(ien), .irq_busy(irq_busy),
  .mem_we(mem_we), .mem_addr(mem_addr), .pc_load(pc_load),
  .pc_inc(pc_inc), .cycle_done(cycle_done)
);

// File: tb/irq_flag_ctl_bench.sv
module irq_flag_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        kbd_strobe = 0, in_read = 0, out_write = 0, prn_accept = 0;
  logic        ien_set = 0, ien_clr = 0, exec_done = 0;
  logic [7:0]  kbd_char = '0, out_char = '0;
  logic [11:0] pc_in = '0;
  logic [7:0]  in_data, out_data;
  logic        in_ready, out_free, ien, irq_busy, mem_we, pc_load, pc_inc, cycle_done;
  logic [11:0] mem_addr, pc_load_val;
  logic [15:0] mem_wdata;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_ctl u_irq_flag_ctl (
    .clk(clk), .rst(rst),
    .kbd_strobe(kbd_strobe), .kbd_char(kbd_char), .in_read(in_read),
    .in_data(in_data), .in_ready(in_ready),
    .out_write(out_write), .out_char(out_char), .prn_accept(prn_accept),
    .out_data(out_data), .out_free(out_free),
    .ien_set(ien_set), .ien_clr(ien_clr), .ien(ien),
    .exec_done(exec_done), .pc_in(pc_in), .irq_busy(irq_busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_load(pc_load), .pc_load_val(pc_load_val),
    .pc_inc(pc_inc), .cycle_done(cycle_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inputs change at a falling edge; one step later one rising edge has passed.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    kbd_strobe = 0; in_read = 0; out_write = 0; prn_accept = 0;
    ien_set = 0; ien_clr = 0; exec_done = 0;
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0;
    chk("R1 in_ready", in_ready, 0);
    chk("R1 out_free", out_free, 1);
    chk("R1 ien", ien, 0);
    chk("R1 busy", irq_busy, 0);
    chk("R1 pulses", {mem_we, pc_load, pc_inc, cycle_done}, 0);
    chk("R1 data", {in_data, out_data}, 0);
  endtask

  task automatic t_input();
    kbd_strobe = 1; kbd_char = 8'hA7; step(); idle();
    chk("R2 char", in_data, 8'hA7);
    chk("R2 ready", in_ready, 1);
    in_read = 1; step(); idle();
    chk("R2 read clears", in_ready, 0);
    kbd_strobe = 1; in_read = 1; kbd_char = 8'h3C; step(); idle();
    chk("R2 strobe wins", in_ready, 1);
    chk("R2 char2", in_data, 8'h3C);
    in_read = 1; step(); idle();
  endtask

  task automatic t_output();
    out_write = 1; out_char = 8'h5E; step(); idle();
    chk("R3 data", out_data, 8'h5E);
    chk("R3 busy dev", out_free, 0);
    prn_accept = 1; step(); idle();
    chk("R3 accept", out_free, 1);
    out_write = 1; prn_accept = 1; out_char = 8'h81; step(); idle();
    chk("R3 write wins", out_free, 0);
    chk("R3 data2", out_data, 8'h81);
  endtask

  task automatic t_ien();
    ien_set = 1; step(); idle();
    chk("R4 set", ien, 1);
    ien_clr = 1; step(); idle();
    chk("R4 clr", ien, 0);
    ien_set = 1; step(); idle();
    ien_set = 1; ien_clr = 1; step(); idle();
    chk("R4 clr wins", ien, 0);
  endtask

  task automatic t_no_request();
    // Flags both 0 here (out_free=0 from t_output, in_ready=0).
    ien_set = 1; step(); idle();
    exec_done = 1; step(); idle();
    chk("R5 no flag", irq_busy, 0);
    prn_accept = 1; step(); idle();
    step();
    chk("R5 no exec_done", irq_busy, 0);
    ien_clr = 1; step(); idle();
    exec_done = 1; step(); idle();
    chk("R5 ien off", irq_busy, 0);
  endtask

  // Full cycle; out_free=1 when entering, optionally in_ready.
  task automatic t_cycle(input logic [11:0] pc, input bit use_input);
    if (use_input) begin
      out_write = 1; out_char = 8'h11; kbd_strobe = 1; kbd_char = 8'h99; step(); idle();
    end
    ien_set = 1; step(); idle();
    pc_in = pc; exec_done = 1; step();
    chk("R5 busy rise", irq_busy, 1);
    chk("R6 no early we", mem_we, 0);
    step();
    pc_in = ~pc;
    chk("R6 no we step0", mem_we, 0);
    step();
    chk("R6 we", mem_we, 1);
    chk("R6 pc_load", pc_load, 1);
    chk("R6 addr", mem_addr, 0);
    chk("R6 load val", pc_load_val, 0);
    chk("R6 wdata", mem_wdata, {4'h0, pc});
    ien_set = 1; step(); ien_set = 0;
    chk("R7 inc", pc_inc, 1);
    chk("R7 done", cycle_done, 1);
    chk("R7 ien clear", ien, 0);
    chk("R7 busy drop", irq_busy, 0);
    chk("R7 we gone", mem_we, 0);
    step();
    exec_done = 0;
    chk("R8 no retrigger", irq_busy, 0);
    chk("R7 pulses end", {pc_inc, cycle_done}, 0);
    if (use_input) begin
      chk("R8 in flag kept", in_ready, 1);
      chk("R8 in data kept", in_data, 8'h99);
      chk("R8 out data kept", out_data, 8'h11);
      chk("R8 out flag kept", out_free, 0);
    end else begin
      chk("R8 out flag kept", out_free, 1);
    end
  endtask

  initial begin
    step();
    t_reset();
    t_input();
    t_output();
    t_ien();
    t_no_request();
    t_cycle(12'h2A5, 0);
    t_cycle(12'hFFF, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule